// File: doc/BRIEF.md
# ADC Sample-Convert Sequencer

This block runs the sample and conversion phases of an external successive-approximation converter core. It opens a sampling window on request from software or by itself in auto-sample mode. It closes that window when the selected end-of-sample event arrives, and then issues a one-cycle start to the converter core. The core answers over a start/busy/data handshake: it raises busy after the start and drops busy once its data is valid. On the cycle busy falls, the sequencer packs the raw 10-bit or 12-bit result into a 16-bit word in the selected format and raises the done flag.

Configuration arrives as plain level inputs, as a register field would drive them. These set the enable, the stop-in-idle behaviour, the resolution, the output format, the end-of-sample source, simultaneous sampling, auto-sampling and the internal sample-time count. The sample and done flags are outputs that software reads back. Software asks for a sample window with a set strobe and, in the software-ended mode, closes it with a clear strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `cfg_on` is 0, the sample flag, the done flag and `conv_start` are 0 from the next cycle on, and `sw_samp_set` has no effect.
- R2: While `cfg_idle_stop` and `idle_mode` are both 1, the sequencer holds its phase and flags and issues no start. With `cfg_idle_stop` at 0, `idle_mode` has no effect.
- R3: A `sw_samp_set` pulse in the idle phase sets the sample flag and clears the done flag on the next cycle.
- R4: With trigger code 3'b000, a `sw_samp_clr` pulse while sampling clears the sample flag and raises `conv_start` on the next cycle.
- R5: With trigger code 3'b001, only a low-to-high transition of `ext_pin` during sampling ends the window. A level already high when sampling began does not end it.
- R6: Trigger codes 3'b010, 3'b011 and 3'b101 end sampling on `tmr3_match`, `pwm1_evt` and `pwm2_evt` respectively. Under each of these codes, the other event inputs are ignored.
- R7: With trigger code 3'b111, the sample flag stays high for exactly N cycles, where N = `cfg_acnt` and a count of 0 acts as 1. Conversion then starts by itself.
- R8: Trigger codes 3'b100 and 3'b110 never start a conversion. The sample flag stays high until the code is changed.
- R9: The formatted result and the done flag are registered on the clock edge that first sees `conv_busy` low after a start. `result_valid` is high for that one cycle.
- R10: In 10-bit mode (`cfg_res12`=0), only `conv_data[9:0]` is used and d9 is its MSB. The formats are: `cfg_fmt` 00 gives {6'b0,d}; 01 gives {7 copies of ~d9, d[8:0]}; 10 gives {d,6'b0}; 11 gives {~d9,d[8:0],6'b0}.
- R11: In 12-bit mode (`cfg_res12`=1), d11 is the MSB. The formats are: 00 gives {4'b0,d}; 01 gives {5 copies of ~d11, d[10:0]}; 10 gives {d,4'b0}; 11 gives {~d11,d[10:0],4'b0}.
- R12: With `cfg_auto` set, the cycle after the done flag rises, the sample flag is set and the done flag is cleared. With `cfg_auto` set in the idle phase, sampling starts without software.
- R13: `simul_rd` shows `cfg_simul` in 10-bit mode and reads 0 in 12-bit mode.
- R14: `conv_start` is a single-cycle pulse. It rises only on the cycle the sample flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on | input | 1 | Module enable |
| cfg_idle_stop | input | 1 | Halt while the device is idle |
| cfg_res12 | input | 1 | 1 = 12-bit single channel, 0 = 10-bit |
| cfg_fmt | input | 2 | Output format code |
| cfg_trig | input | 3 | End-of-sample source code |
| cfg_simul | input | 1 | Simultaneous-sample request |
| cfg_auto | input | 1 | Restart sampling after each conversion |
| cfg_acnt | input | 5 | Auto-convert sample time in cycles |
| sw_samp_set | input | 1 | Software request to open a sample window |
| sw_samp_clr | input | 1 | Software request to close the window (code 000) |
| idle_mode | input | 1 | Device idle indication |
| ext_pin | input | 1 | External interrupt pin level |
| tmr3_match | input | 1 | Timer-3 compare event |
| pwm1_evt | input | 1 | PWM1 interval event |
| pwm2_evt | input | 1 | PWM2 interval event |
| conv_start | output | 1 | Start pulse to the converter core |
| conv_busy | input | 1 | Converter core busy |
| conv_data | input | 12 | Raw converter result |
| samp_flag | output | 1 | Sampling in progress |
| done_flag | output | 1 | Conversion finished |
| simul_rd | output | 1 | Effective simultaneous-sample setting |
| result | output | 16 | Formatted result word |
| result_valid | output | 1 | One-cycle strobe with a new result |

## Verification
A phase register that is stuck or takes a wrong step shows at once on `samp_flag` and `conv_start`. A missing start leaves the sample flag low with no result, and an extra start gives a second conversion that the scoreboard has no entry for. An off-by-one in the sample-time counter changes the measured width of the sample flag by a cycle in the very window it affects. A wrong format path or sign inversion shows on the next `result_valid` as a word that does not match the independently computed value. A wrong latch moment is caught by timing `result_valid` against the falling edge of `conv_busy`.

// File: rtl/adcs_pkg.sv
package adcs_pkg;

    localparam int RAW_W  = 12;
    localparam int LO_W   = 10;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 5;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SAMPLE  = 3'd1,
        PH_LAUNCH  = 3'd2,
        PH_BUSY    = 3'd3,
        PH_RESTART = 3'd4
    } phase_e;

    typedef enum logic [2:0] {
        TRG_SWCLR  = 3'b000,
        TRG_EXTPIN = 3'b001,
        TRG_TMR3   = 3'b010,
        TRG_PWM1   = 3'b011,
        TRG_RSV4   = 3'b100,
        TRG_PWM2   = 3'b101,
        TRG_RSV6   = 3'b110,
        TRG_AUTO   = 3'b111
    } trig_e;

    typedef enum logic [1:0] {
        FMT_UINT  = 2'b00,
        FMT_SINT  = 2'b01,
        FMT_UFRAC = 2'b10,
        FMT_SFRAC = 2'b11
    } fmt_e;

    typedef struct packed {
        logic  res12;
        fmt_e  fmt;
    } pack_cfg_t;

    function automatic logic [WORD_W-1:0] pack_word(
        input logic [RAW_W-1:0] raw,
        input pack_cfg_t        pc
    );
        logic [WORD_W-1:0] w;
        if (pc.res12) begin
            case (pc.fmt)
                FMT_UINT:  w = {{(WORD_W-RAW_W){1'b0}}, raw};
                FMT_SINT:  w = {{(WORD_W-RAW_W+1){~raw[RAW_W-1]}}, raw[RAW_W-2:0]};
                FMT_UFRAC: w = {raw, {(WORD_W-RAW_W){1'b0}}};
                default:   w = {~raw[RAW_W-1], raw[RAW_W-2:0], {(WORD_W-RAW_W){1'b0}}};
            endcase
        end else begin
            case (pc.fmt)
                FMT_UINT:  w = {{(WORD_W-LO_W){1'b0}}, raw[LO_W-1:0]};
                FMT_SINT:  w = {{(WORD_W-LO_W+1){~raw[LO_W-1]}}, raw[LO_W-2:0]};
                FMT_UFRAC: w = {raw[LO_W-1:0], {(WORD_W-LO_W){1'b0}}};
                default:   w = {~raw[LO_W-1], raw[LO_W-2:0], {(WORD_W-LO_W){1'b0}}};
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/adcs_trig_sel.sv
module adcs_trig_sel
    import adcs_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          freeze,
    input  logic          sampling,
    input  logic          samp_entry,
    input  trig_e         trig,
    input  logic [CW-1:0] acnt,
    input  logic          sw_clr,
    input  logic          ext_pin,
    input  logic          tmr3_evt,
    input  logic          pwm1_evt,
    input  logic          pwm2_evt,
    output logic          fire
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic          pin_q;
    logic          pin_rise;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          cnt_hit;
    logic          sel;

    // previous pin level for edge detection
    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= ext_pin;
    end

    assign pin_rise = ext_pin & ~pin_q;

    // sample-time counter: zero means one cycle
    assign lim     = (acnt == '0) ? ONE : acnt;
    assign cnt_hit = (cnt == lim - ONE);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (samp_entry) begin
            cnt <= '0;
        end else if (sampling && !freeze && !cnt_hit) begin
            cnt <= cnt + ONE;
        end
    end

    always_comb begin
        case (trig)
            TRG_SWCLR:  sel = sw_clr;
            TRG_EXTPIN: sel = pin_rise;
            TRG_TMR3:   sel = tmr3_evt;
            TRG_PWM1:   sel = pwm1_evt;
            TRG_PWM2:   sel = pwm2_evt;
            TRG_AUTO:   sel = cnt_hit;
            default:    sel = 1'b0;
        endcase
    end

    assign fire = sampling & ~freeze & active & sel;

endmodule

// File: rtl/adcs_phase_fsm.sv
module adcs_phase_fsm
    import adcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active,
    input  logic   freeze,
    input  logic   auto_samp,
    input  logic   sw_set,
    input  logic   fire,
    input  logic   busy,
    output phase_e phase,
    output logic   samp,
    output logic   done,
    output logic   start,
    output logic   latch,
    output logic   samp_entry
);

    logic go;

    assign go = active & ~freeze;

    assign samp_entry = go & (((phase == PH_IDLE) & (sw_set | auto_samp)) |
                              (phase == PH_RESTART));
    assign latch      = go & (phase == PH_BUSY) & ~busy;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            phase <= PH_IDLE;
            samp  <= 1'b0;
            done  <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (!freeze) begin
                case (phase)
                    PH_IDLE: begin
                        if (sw_set || auto_samp) begin
                            samp  <= 1'b1;
                            done  <= 1'b0;
                            phase <= PH_SAMPLE;
                        end
                    end
                    PH_SAMPLE: begin
                        if (fire) begin
                            samp  <= 1'b0;
                            start <= 1'b1;
                            phase <= PH_LAUNCH;
                        end
                    end
                    PH_LAUNCH: begin
                        if (busy) phase <= PH_BUSY;
                    end
                    PH_BUSY: begin
                        if (!busy) begin
                            done  <= 1'b1;
                            phase <= auto_samp ? PH_RESTART : PH_IDLE;
                        end
                    end
                    PH_RESTART: begin
                        samp  <= 1'b1;
                        done  <= 1'b0;
                        phase <= PH_SAMPLE;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/adcs_packer.sv
module adcs_packer
    import adcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch,
    input  logic [RAW_W-1:0]  raw,
    input  pack_cfg_t         pc,
    output logic [WORD_W-1:0] word,
    output logic              valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= latch;
            if (latch) word <= pack_word(raw, pc);
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_on,
    input  logic              cfg_idle_stop,
    input  logic              cfg_res12,
    input  logic [1:0]        cfg_fmt,
    input  logic [2:0]        cfg_trig,
    input  logic              cfg_simul,
    input  logic              cfg_auto,
    input  logic [CNT_W-1:0]  cfg_acnt,
    input  logic              sw_samp_set,
    input  logic              sw_samp_clr,
    input  logic              idle_mode,
    input  logic              ext_pin,
    input  logic              tmr3_match,
    input  logic              pwm1_evt,
    input  logic              pwm2_evt,
    output logic              conv_start,
    input  logic              conv_busy,
    input  logic [RAW_W-1:0]  conv_data,
    output logic              samp_flag,
    output logic              done_flag,
    output logic              simul_rd,
    output logic [WORD_W-1:0] result,
    output logic              result_valid
);

    logic      freeze;
    logic      fire;
    logic      latch;
    logic      samp_entry;
    phase_e    phase;
    pack_cfg_t pc;

    assign freeze   = cfg_idle_stop & idle_mode;
    assign simul_rd = cfg_simul & ~cfg_res12;
    assign pc       = '{res12: cfg_res12, fmt: fmt_e'(cfg_fmt)};

    adcs_trig_sel #(.CW(CNT_W)) trig_i (
        .clk        (clk),
        .rst        (rst),
        .active     (cfg_on),
        .freeze     (freeze),
        .sampling   (phase == PH_SAMPLE),
        .samp_entry (samp_entry),
        .trig       (trig_e'(cfg_trig)),
        .acnt       (cfg_acnt),
        .sw_clr     (sw_samp_clr),
        .ext_pin    (ext_pin),
        .tmr3_evt   (tmr3_match),
        .pwm1_evt   (pwm1_evt),
        .pwm2_evt   (pwm2_evt),
        .fire       (fire)
    );

    adcs_phase_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .active     (cfg_on),
        .freeze     (freeze),
        .auto_samp  (cfg_auto),
        .sw_set     (sw_samp_set),
        .fire       (fire),
        .busy       (conv_busy),
        .phase      (phase),
        .samp       (samp_flag),
        .done       (done_flag),
        .start      (conv_start),
        .latch      (latch),
        .samp_entry (samp_entry)
    );

    adcs_packer pack_i (
        .clk   (clk),
        .rst   (rst),
        .latch (latch),
        .raw   (conv_data),
        .pc    (pc),
        .word  (result),
        .valid (result_valid)
    );

endmodule

// File: rtl/adcs_chk.sv
module adcs_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_on,
    input logic       cfg_idle_stop,
    input logic       idle_mode,
    input logic [2:0] cfg_trig,
    input logic       samp_flag,
    input logic       done_flag,
    input logic       conv_start,
    input logic       result_valid
);

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_on |=> (!samp_flag && !done_flag && !conv_start));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_on && cfg_idle_stop && idle_mode) |=>
            ($stable(samp_flag) && $stable(done_flag) && !conv_start));

    // R8
    rsv_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_on && samp_flag && (cfg_trig == 3'b100 || cfg_trig == 3'b110)) |=> samp_flag);

    // R9
    valid_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> done_flag);

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R14
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R14
    start_on_samp_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_start) |-> $fell(samp_flag));

endmodule

bind adc_seq_ctrl adcs_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_on        (cfg_on),
    .cfg_idle_stop (cfg_idle_stop),
    .idle_mode     (idle_mode),
    .cfg_trig      (cfg_trig),
    .samp_flag     (samp_flag),
    .done_flag     (done_flag),
    .conv_start    (conv_start),
    .result_valid  (result_valid)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_on = 0, cfg_idle_stop = 0, cfg_res12 = 0;
    logic [1:0]  cfg_fmt = 0;
    logic [2:0]  cfg_trig = 0;
    logic        cfg_simul = 0, cfg_auto = 0;
    logic [4:0]  cfg_acnt = 0;
    logic        sw_samp_set = 0, sw_samp_clr = 0, idle_mode = 0;
    logic        ext_pin = 0, tmr3_match = 0, pwm1_evt = 0, pwm2_evt = 0;
    logic        conv_start;
    logic        conv_busy = 0;
    logic [11:0] conv_data = 0;
    logic        samp_flag, done_flag, simul_rd, result_valid;
    logic [15:0] result;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          fall_cyc = -10;
    int          start_cnt = 0;
    int          lat = 0;
    logic [11:0] cur_raw = 0;
    logic [15:0] sb_q[$];
    bit          finished = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl dut_i (.*);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int raw, input bit r12, input int fmt);
        int bits = r12 ? 12 : 10;
        int sh   = 16 - bits;
        int v    = raw & ((1 << bits) - 1);
        int t    = v ^ (1 << (bits - 1));
        case (fmt)
            0:       return 16'(v);
            1:       return (t >= (1 << (bits - 1))) ? 16'(t - (1 << bits)) : 16'(t);
            2:       return 16'(v << sh);
            default: return 16'(t << sh);
        endcase
    endfunction

    // converter core model
    always @(negedge clk) begin
        if (rst) begin
            conv_busy = 0;
        end else if (conv_busy) begin
            if (lat == 0) begin
                conv_data = cfg_res12 ? cur_raw : {2'b10, cur_raw[9:0]};
                conv_busy = 0;
                fall_cyc  = cyc;
            end else begin
                lat--;
            end
        end else if (conv_start) begin
            start_cnt++;
            conv_busy = 1;
            lat       = 3;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && result_valid) begin
            if (sb_q.size() == 0) begin
                check(0, "R9 unexpected result", {16'h0, result}, 32'h0);
            end else begin
                logic [15:0] e;
                e = sb_q.pop_front();
                check(result == e, cfg_res12 ? "R11" : "R10", {16'h0, result}, {16'h0, e});
            end
        end
    end

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: sw_samp_set = 1;
            1: sw_samp_clr = 1;
            2: ext_pin     = 1;
            3: tmr3_match  = 1;
            4: pwm1_evt    = 1;
            default: pwm2_evt = 1;
        endcase
        @(negedge clk);
        sw_samp_set = 0; sw_samp_clr = 0; ext_pin = 0;
        tmr3_match = 0; pwm1_evt = 0; pwm2_evt = 0;
    endtask

    task automatic wait_valid(input string req);
        bit got = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (result_valid) begin got = 1; break; end
        end
        check(got, req, {31'h0, got}, 1);
        check(done_flag == 1, "R9 done", {31'h0, done_flag}, 1);
        check(cyc == fall_cyc + 1, "R9 latch timing", cyc, fall_cyc + 1);
    endtask

    task automatic fire_trig(input logic [2:0] t);
        case (t)
            3'b000: pulse(1);
            3'b001: pulse(2);
            3'b010: pulse(3);
            3'b011: pulse(4);
            3'b101: pulse(5);
            default: ;
        endcase
    endtask

    task automatic do_conv(input logic [11:0] raw, input bit r12, input int fmt, input logic [2:0] t);
        @(negedge clk);
        cfg_res12 = r12; cfg_fmt = 2'(fmt); cfg_trig = t; cur_raw = raw;
        sb_q.push_back(exp_word(raw, r12, fmt));
        pulse(0);
        fire_trig(t);
        wait_valid(r12 ? "R11 conv" : "R10 conv");
    endtask

    task automatic measure_auto(input int n, input int expn);
        int w = 0;
        @(negedge clk);
        cfg_trig = 3'b111; cfg_acnt = 5'(n); cur_raw = 12'h123;
        cfg_res12 = 0; cfg_fmt = 0;
        sb_q.push_back(exp_word(12'h123, 0, 0));
        sw_samp_set = 1;
        @(negedge clk);
        sw_samp_set = 0;
        while (samp_flag && w < 100) begin
            w++;
            @(negedge clk);
        end
        check(w == expn, "R7 sample width", w, expn);
        wait_valid("R7 conv");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!samp_flag && !done_flag && !conv_start && !result_valid, "R1 reset",
              {samp_flag, done_flag, conv_start, result_valid}, 0);

        // R1: off ignores set
        pulse(0);
        check(samp_flag == 0, "R1 set while off", samp_flag, 0);

        cfg_on = 1;
        // R3, R4, R14 explicit timing
        @(negedge clk);
        cur_raw = 12'h2A5; cfg_trig = 0; cfg_fmt = 0;
        sb_q.push_back(exp_word(12'h2A5, 0, 0));
        sw_samp_set = 1;
        @(negedge clk);
        sw_samp_set = 0;
        check(samp_flag == 1, "R3 samp set", samp_flag, 1);
        repeat (3) @(negedge clk);
        check(conv_start == 0 && samp_flag == 1, "R4 no early start", {conv_start, samp_flag}, 1);
        sw_samp_clr = 1;
        @(negedge clk);
        sw_samp_clr = 0;
        check(samp_flag == 0 && conv_start == 1, "R4 clear starts", {samp_flag, conv_start}, 1);
        @(negedge clk);
        check(conv_start == 0, "R14 single pulse", conv_start, 0);
        wait_valid("R9 first conv");
        pulse(0);
        check(done_flag == 0 && samp_flag == 1, "R3 done cleared", {done_flag, samp_flag}, 2'b01);
        cfg_on = 0;
        @(negedge clk);
        check(samp_flag == 0 && done_flag == 0, "R1 off clears", {samp_flag, done_flag}, 0);
        sb_q.delete();
        cfg_on = 1;

        // R10, R11 format sweep
        for (int f = 0; f < 4; f++) begin
            do_conv(12'h000, 0, f, 3'b000);
            do_conv(12'h3FF, 0, f, 3'b000);
            do_conv(12'h200, 0, f, 3'b000);
            do_conv(12'h1A5, 0, f, 3'b000);
            do_conv(12'hFFF, 1, f, 3'b000);
            do_conv(12'h800, 1, f, 3'b000);
            do_conv(12'h7FF, 1, f, 3'b000);
            do_conv(12'hA5C, 1, f, 3'b000);
        end

        // R6: each hardware source
        do_conv(12'h155, 0, 1, 3'b010);
        do_conv(12'h0F3, 1, 3, 3'b011);
        do_conv(12'h3C1, 0, 3, 3'b101);

        // R6: other events ignored under timer code
        @(negedge clk);
        cfg_trig = 3'b010; cur_raw = 12'h0AA; cfg_res12 = 0; cfg_fmt = 0;
        s0 = start_cnt;
        pulse(0);
        pulse(1); pulse(2); pulse(4); pulse(5);
        check(samp_flag == 1 && start_cnt == s0, "R6 others ignored", {samp_flag, 8'(start_cnt - s0)}, 9'h100);
        sb_q.push_back(exp_word(12'h0AA, 0, 0));
        pulse(3);
        wait_valid("R6 timer conv");

        // R5: held level does not fire, fresh edge does
        @(negedge clk);
        cfg_trig = 3'b001; cur_raw = 12'h301; ext_pin = 1;
        s0 = start_cnt;
        @(negedge clk);
        sw_samp_set = 1;
        @(negedge clk);
        sw_samp_set = 0;
        repeat (4) @(negedge clk);
        check(samp_flag == 1 && start_cnt == s0, "R5 level ignored", {samp_flag, 8'(start_cnt - s0)}, 9'h100);
        ext_pin = 0;
        sb_q.push_back(exp_word(12'h301, 0, 0));
        pulse(2);
        wait_valid("R5 edge conv");

        // R8: reserved codes
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            cfg_trig = (k == 0) ? 3'b100 : 3'b110; cur_raw = 12'h0C3;
            s0 = start_cnt;
            pulse(0);
            pulse(1); pulse(2); pulse(3); pulse(4); pulse(5);
            repeat (35) @(negedge clk);
            check(samp_flag == 1 && start_cnt == s0, "R8 reserved holds", {samp_flag, 8'(start_cnt - s0)}, 9'h100);
            cfg_trig = 3'b000;
            sb_q.push_back(exp_word(12'h0C3, 0, 0));
            pulse(1);
            wait_valid("R8 recovery conv");
        end

        // R7: auto sample time
        measure_auto(5, 5);
        measure_auto(1, 1);
        measure_auto(0, 1);
        measure_auto(31, 31);

        // R2: idle stop
        @(negedge clk);
        cfg_trig = 3'b000; cur_raw = 12'h111;
        pulse(0);
        idle_mode = 1; cfg_idle_stop = 1;
        s0 = start_cnt;
        pulse(1);
        repeat (2) @(negedge clk);
        check(samp_flag == 1 && start_cnt == s0, "R2 frozen", {samp_flag, 8'(start_cnt - s0)}, 9'h100);
        cfg_idle_stop = 0;
        sb_q.push_back(exp_word(12'h111, 0, 0));
        pulse(1);
        wait_valid("R2 idle ignored");
        idle_mode = 0;

        // R12: auto-sample restart
        @(negedge clk);
        cfg_trig = 3'b111; cfg_acnt = 5'd3; cur_raw = 12'h222; cfg_fmt = 2;
        for (int k = 0; k < 3; k++) sb_q.push_back(exp_word(12'h222, 0, 2));
        cfg_auto = 1;
        for (int k = 0; k < 2; k++) begin
            wait_valid("R12 auto conv");
            @(negedge clk);
            check(samp_flag == 1 && done_flag == 0, "R12 restart", {samp_flag, done_flag}, 2'b10);
        end
        cfg_auto = 0;
        wait_valid("R12 last conv");
        repeat (10) @(negedge clk);
        check(samp_flag == 0 && sb_q.size() == 0, "R12 stops", {samp_flag, 8'(sb_q.size())}, 0);

        // R13
        cfg_simul = 1; cfg_res12 = 0;
        @(negedge clk);
        check(simul_rd == 1, "R13 10-bit", simul_rd, 1);
        cfg_res12 = 1;
        @(negedge clk);
        check(simul_rd == 0, "R13 12-bit", simul_rd, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule